// File: doc/BRIEF.md
# I2C Slave Port with Conversion Gating

This block is the two-wire serial front end of an eight-channel converter. It runs on a fast system clock and oversamples the bus. SCL and SDA are brought in through a two-flop synchroniser, and the block drives SDA only through an open-drain enable: it pulls the line low or releases it. START, repeated START and STOP are decoded from SDA edges that occur while SCL is high. The first byte after a START carries a 7-bit address and a direction bit. The block answers its own address, which is a 7-bit input chosen outside the block. It also answers a broadcast address, but only for writes.

A write carries one configuration byte. The first six bits of that byte become the 6-bit configuration output. A read returns the last 12-bit conversion result followed by four zero bits. While the converter reports busy, every address is refused. A new conversion is requested on a STOP that ends an acknowledged transfer. In a write, repeated START, read sequence, the request comes instead once the sixteenth read bit has left. Two single-cycle pulses tell the analog side when to begin acquiring and when to wake.

Top module: `i2c_cvt_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, cfg_o is 0 and conv_start_o, acq_start_o and wake_o are 0.
- R2: An address byte whose upper seven bits equal dev_addr_i is acknowledged: SDA is held low during the ninth SCL clock. Any other address, except the broadcast one, is not acknowledged.
- R3: The broadcast address 7'b1110111 is acknowledged with R/W=0 (write) and refused with R/W=1 (read). A broadcast write loads cfg_o like an addressed write.
- R4: While conv_busy_i is 1, every address byte is refused. A STOP that follows such a refused byte does not raise conv_start_o.
- R5: In a write, the data byte is sampled MSB first on rising SCL and is acknowledged. Its first six bits load cfg_o[5:0], with the first bit in cfg_o[5]. The last two bits have no effect.
- R6: A read returns 16 bits MSB first: result_i[11:0], then 4'b0000. SDA changes only while SCL is low. The first data byte is continued only if the master acknowledges it.
- R7: A STOP after an acknowledged transfer raises conv_start_o once. A STOP after a refused address does not.
- R8: In a write, repeated START, read sequence, conv_start_o is raised after the sixteenth read bit, with the new cfg_o already in place. The STOP that follows raises no second request.
- R9: A repeated START by itself does not raise conv_start_o.
- R10: acq_start_o pulses on the rising edge of the ninth SCL clock of an acknowledged read address. In a write, it pulses on the falling edge of the sixth SCL clock of the data byte.
- R11: wake_o pulses once when an address byte matches dev_addr_i, whether or not the converter is busy.
- R12: A STOP or START that arrives after one to seven bits of a byte aborts the transfer. The block returns to idle, cfg_o is unchanged, no conversion is requested, and bytes that follow are not acknowledged until a fresh START.
- R13: conv_start_o, acq_start_o and wake_o are each one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_addr_i | input | 7 | Own 7-bit slave address |
| conv_busy_i | input | 1 | Converter is running a conversion |
| result_i | input | 12 | Last conversion result |
| conv_start_o | output | 1 | Single-cycle conversion request |
| acq_start_o | output | 1 | Single-cycle start-of-acquisition pulse |
| wake_o | output | 1 | Single-cycle wake pulse on own-address match |
| cfg_o | output | 6 | Configuration from the last complete write |

## Verification
Every bus event reaches the outputs on the third rising clock edge after the SCL or SDA change: two synchroniser flops, then the registered control state. This covers the acknowledge enable, each read data bit, cfg_o and the three pulses. The bench holds each SCL phase for eight clocks and samples SDA at the end of the high phase, well past that delay. Pulses are counted by a monitor on every clock edge, and each count is compared once the bus phase that should cause it is over. The monitor also records the SCL edge count and SCL level at the moment of acquisition, which fixes which clock produced it.

// File: rtl/i2c_cvt_pkg.sv
package i2c_cvt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGN
  } st_e;
endpackage

// File: rtl/i2c_cvt_sync.sv
module i2c_cvt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES:0][W-1:0] pipe;

  // idle bus is high, reset to ones so no false edge appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= '1;
    else         pipe <= {pipe[STAGES-1:0], d_i};
  end

  assign q_o      = pipe[STAGES-1];
  assign q_prev_o = pipe[STAGES];
endmodule

// File: rtl/i2c_cvt_cond.sv
module i2c_cvt_cond (
  input  logic scl_s_i,
  input  logic scl_p_i,
  input  logic sda_s_i,
  input  logic sda_p_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_hold;

  assign scl_hold   = scl_s_i & scl_p_i;
  assign scl_rise_o = scl_s_i & ~scl_p_i;
  assign scl_fall_o = ~scl_s_i & scl_p_i;
  assign start_o    = scl_hold & sda_p_i & ~sda_s_i;
  assign stop_o     = scl_hold & ~sda_p_i & sda_s_i;
endmodule

// File: rtl/i2c_cvt_ctrl.sv
module i2c_cvt_ctrl
  import i2c_cvt_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int RES_W    = 12,
  parameter int RD_W     = 16,
  parameter int CFG_W    = 6,
  parameter int ACQ_FALL = 6,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 7'h77
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              busy_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              sda_oe_o,
  output logic              conv_o,
  output logic              acq_o,
  output logic              wake_o,
  output logic [CFG_W-1:0]  cfg_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PAD_W = RD_W - RES_W;
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_ACQ  = CNT_W'(ACQ_FALL);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic [RD_W-1:0]   rd_sh;
  logic [CFG_W-1:0]  cfg_q;
  logic oe_q, ack_q, rw_q, pend_q, wr_q, byte2_q, mack_q;
  logic conv_q, acq_q, wake_q;

  logic own_hit, gen_hit, ack_ok, mid_byte;

  assign own_hit  = (sh == dev_addr_i);
  assign gen_hit  = (sh == GEN_ADDR);
  // R3/R4: broadcast only for writes, nothing while busy
  assign ack_ok   = !busy_i && (own_hit || (gen_hit && !sda_i));
  assign mid_byte = (st == ST_ADDR || st == ST_WDATA || st == ST_RDATA) && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rd_sh   <= '0;
      cfg_q   <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      pend_q  <= 1'b0;
      wr_q    <= 1'b0;
      byte2_q <= 1'b0;
      mack_q  <= 1'b0;
      conv_q  <= 1'b0;
      acq_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      conv_q <= 1'b0;
      acq_q  <= 1'b0;
      wake_q <= 1'b0;
      if (stop_i) begin
        // R7/R12: request only on a clean stop after an acked access
        oe_q   <= 1'b0;
        st     <= ST_IDLE;
        cnt    <= '0;
        pend_q <= 1'b0;
        wr_q   <= 1'b0;
        if (pend_q && !mid_byte) conv_q <= 1'b1;
      end else if (start_i) begin
        oe_q <= 1'b0;
        cnt  <= '0;
        if (mid_byte) begin
          st     <= ST_IDLE;
          pend_q <= 1'b0;
          wr_q   <= 1'b0;
        end else begin
          st <= ST_ADDR;
        end
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh  <= {sh[ADDR_W-2:0], sda_i};
              cnt <= cnt + C_ONE;
              if (cnt == C_LAST) begin
                cnt    <= '0;
                st     <= ST_AACK;
                rw_q   <= sda_i;
                ack_q  <= ack_ok;
                wake_q <= own_hit;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              if (cnt == '0) begin
                oe_q <= ack_q;
                cnt  <= C_ONE;
              end else begin
                cnt <= '0;
                if (!ack_q) begin
                  oe_q <= 1'b0;
                  st   <= ST_IGN;
                end else if (rw_q) begin
                  st      <= ST_RDATA;
                  oe_q    <= ~rd_sh[RD_W-1];
                  byte2_q <= 1'b0;
                end else begin
                  st   <= ST_WDATA;
                  oe_q <= 1'b0;
                end
              end
            end else if (scl_rise_i && cnt == C_ONE && ack_q) begin
              pend_q <= 1'b1;
              if (rw_q) begin
                acq_q <= 1'b1;
                rd_sh <= {result_i, {PAD_W{1'b0}}};
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[ADDR_W-2:0], sda_i};
              cnt <= cnt + C_ONE;
              if (cnt == C_LAST) begin
                cfg_q <= sh[ADDR_W-1 -: CFG_W];
                wr_q  <= 1'b1;
                cnt   <= '0;
                st    <= ST_WACK;
              end
            end else if (scl_fall_i && cnt == C_ACQ) begin
              acq_q <= 1'b1;
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              if (cnt == '0) begin
                oe_q <= 1'b1;
                cnt  <= C_ONE;
              end else begin
                oe_q <= 1'b0;
                cnt  <= '0;
                st   <= ST_IGN;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + C_ONE;
            end else if (scl_fall_i) begin
              rd_sh <= rd_sh << 1;
              if (cnt == C_FULL) begin
                oe_q <= 1'b0;
                cnt  <= '0;
                st   <= ST_RACK;
                // R8: write then read in one bus transaction
                if (byte2_q && wr_q && pend_q) begin
                  conv_q <= 1'b1;
                  pend_q <= 1'b0;
                end
              end else begin
                oe_q <= ~rd_sh[RD_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q && !byte2_q) begin
                st      <= ST_RDATA;
                byte2_q <= 1'b1;
                oe_q    <= ~rd_sh[RD_W-1];
              end else begin
                st   <= ST_IGN;
                oe_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign conv_o   = conv_q;
  assign acq_o    = acq_q;
  assign wake_o   = wake_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/i2c_cvt_slave.sv
module i2c_cvt_slave #(
  parameter int ADDR_W     = 7,
  parameter int RES_W      = 12,
  parameter int RD_W       = 16,
  parameter int CFG_W      = 6,
  parameter int SYNC_STAGE = 2,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 7'h77
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              conv_busy_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              conv_start_o,
  output logic              acq_start_o,
  output logic              wake_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic [1:0] bus_s, bus_p;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_cvt_sync #(.W(2), .STAGES(SYNC_STAGE)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({scl_i, sda_i}),
    .q_o      (bus_s),
    .q_prev_o (bus_p)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2c_cvt_cond u_cond (
    .scl_s_i    (scl_s),
    .scl_p_i    (bus_p[1]),
    .sda_s_i    (sda_s),
    .sda_p_i    (bus_p[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_cvt_ctrl #(
    .ADDR_W   (ADDR_W),
    .RES_W    (RES_W),
    .RD_W     (RD_W),
    .CFG_W    (CFG_W),
    .GEN_ADDR (GEN_ADDR)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .sda_i      (sda_s),
    .dev_addr_i (dev_addr_i),
    .busy_i     (conv_busy_i),
    .result_i   (result_i),
    .sda_oe_o   (sda_oe_o),
    .conv_o     (conv_start_o),
    .acq_o      (acq_start_o),
    .wake_o     (wake_o),
    .cfg_o      (cfg_o)
  );
endmodule

// File: rtl/i2c_cvt_slave_chk.sv
module i2c_cvt_slave_chk #(
  parameter int CFG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             conv_busy_i,
  input logic             conv_start_o,
  input logic             acq_start_o,
  input logic             wake_o,
  input logic [CFG_W-1:0] cfg_o
);
  p_oe_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  p_cfg_scl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o != $past(cfg_o)) |-> scl_s);

  p_conv_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_acq_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |=> !acq_start_o);

  p_wake_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_conv_not_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !conv_busy_i);

  p_acq_conv_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_start_o, acq_start_o}));
endmodule

bind i2c_cvt_slave i2c_cvt_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_s        (scl_s),
  .sda_oe_o     (sda_oe_o),
  .conv_busy_i  (conv_busy_i),
  .conv_start_o (conv_start_o),
  .acq_start_o  (acq_start_o),
  .wake_o       (wake_o),
  .cfg_o        (cfg_o)
);

// File: tb/i2c_cvt_slave_bench.sv
module i2c_cvt_slave_bench;
  localparam int H        = 8;
  localparam int BUSY_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [6:0]  dev_addr = 7'h08;
  logic [11:0] result = 12'hA5C;
  logic        busy;
  logic        sda_oe, conv_p, acq_p, wake_p;
  logic [5:0]  cfg;
  wire         sda_bus = sda_m & ~sda_oe;

  i2c_cvt_slave u_i2c_cvt_slave (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .dev_addr_i   (dev_addr),
    .conv_busy_i  (busy),
    .result_i     (result),
    .conv_start_o (conv_p),
    .acq_start_o  (acq_p),
    .wake_o       (wake_p),
    .cfg_o        (cfg)
  );

  int n_chk = 0, n_err = 0;
  int n_conv = 0, n_acq = 0, n_wake = 0, rise_cnt = 0, acq_rise = 0;
  int busy_cnt = 0, pulse_viol = 0, oe_viol = 0, base = 0;
  logic acq_scl = 1'b0, scl_d = 1'b1, oe_d = 1'b0;
  logic conv_d = 1'b0, acq_d = 1'b0, wake_d = 1'b0;

  assign busy = (busy_cnt != 0);

  // converter model and event monitor
  always @(posedge clk) begin
    scl_d  <= scl;
    oe_d   <= sda_oe;
    conv_d <= conv_p;
    acq_d  <= acq_p;
    wake_d <= wake_p;
    if (scl && !scl_d) rise_cnt <= rise_cnt + 1;
    if (conv_p) begin n_conv <= n_conv + 1; busy_cnt <= BUSY_CYC; end
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (acq_p) begin n_acq <= n_acq + 1; acq_rise <= rise_cnt; acq_scl <= scl; end
    if (wake_p) n_wake <= n_wake + 1;
    if ((conv_p && conv_d) || (acq_p && acq_d) || (wake_p && wake_d)) pulse_viol <= pulse_viol + 1;
    if (rst_n && (sda_oe != oe_d) && scl) oe_viol <= oe_viol + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(2); sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl = 1'b0; tick(H);
    base = rise_cnt;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic bit_x(input logic b, output logic r);
    tick(2); sda_m = b; tick(H); scl = 1'b1; tick(H);
    r = sda_bus; scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); d[i] = r; end
    bit_x(~mack, r);
  endtask

  task automatic wait_idle();
    tick(BUSY_CYC + 60);
  endtask

  task automatic t_reset();
    chk("R1 oe", int'(sda_oe), 0);
    chk("R1 cfg", int'(cfg), 0);
    chk("R1 pulses", int'({conv_p, acq_p, wake_p}), 0);
  endtask

  task automatic t_write();
    logic ack; int c0, a0, w0;
    c0 = n_conv; a0 = n_acq; w0 = n_wake;
    bus_start();
    wr_byte({7'h08, 1'b0}, ack); chk("R2 own addr ack", int'(ack), 1);
    wr_byte(8'b1011_0111, ack);  chk("R5 data ack", int'(ack), 1);
    chk("R5 cfg", int'(cfg), 6'b101101);
    chk("R10 write acq count", n_acq - a0, 1);
    chk("R10 write acq clock", acq_rise - base, 15);
    chk("R10 write acq on fall", int'(acq_scl), 0);
    chk("R7 no conv before stop", n_conv - c0, 0);
    bus_stop(); tick(4);
    chk("R7 conv on stop", n_conv - c0, 1);
    chk("R11 wake count", n_wake - w0, 1);
  endtask

  task automatic t_nomatch();
    logic ack; int c0, w0;
    wait_idle(); c0 = n_conv; w0 = n_wake;
    bus_start();
    wr_byte({7'h18, 1'b0}, ack); chk("R2 foreign addr nak", int'(ack), 0);
    bus_stop(); tick(4);
    chk("R7 no conv after nak", n_conv - c0, 0);
    chk("R11 no wake foreign", n_wake - w0, 0);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] d; int c0, a0;
    wait_idle(); c0 = n_conv; a0 = n_acq;
    bus_start();
    wr_byte({7'h08, 1'b1}, ack); chk("R2 read addr ack", int'(ack), 1);
    chk("R10 read acq count", n_acq - a0, 1);
    chk("R10 read acq clock", acq_rise - base, 9);
    chk("R10 read acq on rise", int'(acq_scl), 1);
    rd_byte(1'b1, d); chk("R6 first byte", int'(d), 8'hA5);
    rd_byte(1'b0, d); chk("R6 second byte", int'(d), 8'hC0);
    chk("R7 read-only no early conv", n_conv - c0, 0);
    bus_stop(); tick(4);
    chk("R7 conv after read stop", n_conv - c0, 1);
  endtask

  task automatic t_global();
    logic ack; int c0;
    wait_idle(); c0 = n_conv;
    bus_start();
    wr_byte({7'h77, 1'b0}, ack); chk("R3 broadcast write ack", int'(ack), 1);
    wr_byte(8'b0100_1100, ack);
    chk("R3 broadcast cfg", int'(cfg), 6'b010011);
    bus_stop(); tick(4);
    chk("R3 broadcast conv", n_conv - c0, 1);
    wait_idle(); c0 = n_conv;
    bus_start();
    wr_byte({7'h77, 1'b1}, ack); chk("R3 broadcast read nak", int'(ack), 0);
    bus_stop(); tick(4);
    chk("R3 no conv after read nak", n_conv - c0, 0);
  endtask

  task automatic t_busy();
    logic ack; int c0, w0;
    wait_idle();
    bus_start();
    wr_byte({7'h08, 1'b0}, ack);
    wr_byte(8'b0100_1100, ack);
    bus_stop(); tick(4);
    c0 = n_conv; w0 = n_wake;
    chk("R4 converter busy", int'(busy), 1);
    bus_start();
    wr_byte({7'h08, 1'b0}, ack); chk("R4 nak while busy", int'(ack), 0);
    chk("R11 wake while busy", n_wake - w0, 1);
    bus_stop(); tick(4);
    chk("R4 no conv after busy nak", n_conv - c0, 0);
  endtask

  task automatic t_wsr();
    logic ack; logic [7:0] d; int c0;
    wait_idle(); c0 = n_conv; result = 12'h3E7;
    bus_start();
    wr_byte({7'h08, 1'b0}, ack);
    wr_byte(8'b1100_1011, ack);
    bus_start();
    chk("R9 no conv on repeated start", n_conv - c0, 0);
    wr_byte({7'h08, 1'b1}, ack); chk("R8 read ack after sr", int'(ack), 1);
    rd_byte(1'b1, d); chk("R8 byte 1", int'(d), 8'h3E);
    rd_byte(1'b0, d); chk("R8 byte 2", int'(d), 8'h70);
    chk("R8 conv after 16th bit", n_conv - c0, 1);
    chk("R8 new cfg in place", int'(cfg), 6'b110010);
    bus_stop(); tick(4);
    chk("R8 no second conv", n_conv - c0, 1);
  endtask

  task automatic t_abort();
    logic ack, r; int c0;
    wait_idle(); c0 = n_conv;
    bus_start();
    wr_byte({7'h08, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bit_x(1'b0, r);
    bus_stop(); tick(4);
    chk("R12 cfg kept on stop abort", int'(cfg), 6'b110010);
    chk("R12 no conv on stop abort", n_conv - c0, 0);
    bus_start();
    for (int i = 0; i < 3; i++) bit_x(1'b0, r);
    bus_start();
    wr_byte({7'h08, 1'b0}, ack); chk("R12 idle after start abort", int'(ack), 0);
    bus_stop(); tick(4);
    chk("R12 no conv after start abort", n_conv - c0, 0);
    chk("R12 cfg kept on start abort", int'(cfg), 6'b110010);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_write();
    t_nomatch();
    t_read();
    t_global();
    t_busy();
    t_wsr();
    t_abort();
    tick(10);
    chk("R13 single-cycle pulses", pulse_viol, 0);
    chk("R6 sda steady while scl high", oe_viol, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end
endmodule